// File: doc/BRIEF.md
# Prescaled modulus counter time base

This block is the time base of one timer channel. An up-counter runs from zero to a programmable match value and then starts over. It advances on a count tick. The tick comes either from an internal divider or from an external event strobe. The internal divider is fed by a prescaler enable pulse and divides it by one to four.

The timing of the restart after a match can be chosen.

- **Clear-at-start:** the counter drops to zero on the system cycle right after it reaches the match value. It then either resumes on the next tick, or first ignores one tick. Which of the two depends on clock source, divide ratio and mode.
- **Clear-at-end:** the counter holds the match value until the next tick, and that tick loads zero.

A PWM-style mode always uses clear-at-start timing. Every match raises a one-cycle match pulse and sets a sticky flag that software-side logic clears with a strobe.

Top module: `mct_timebase`

## Requirements
- R1: With the internal source selected, the ratio field r (0..3) makes the count tick occur on every (r+1)-th prescaler enable pulse. Between samples the counter only holds, advances by one (modulo 2^CNT_W) or goes to zero.
- R2: With the external source selected (extSel=1), the count tick is the extEvent strobe, and prescaler enable pulses have no effect on the count.
- R3: With the internal source, ratio field 0, enable pulses on every cycle, clear-at-start and a match value of 3, the count seen on successive cycles after reset is 0,1,2,3,0,1,2,3.
- R4: In clear-at-start timing (clrAtEnd=0 or pwmMode=1), when the counter equals the match value during counting, matchPulse is high for that one cycle and the counter is zero on the next cycle, whether or not a tick is present.
- R5: After a clear-at-start clear, the first tick is ignored and the second tick sets the count to 1 when the divide ratio is greater than one and either the source is internal or pwmMode=1. Otherwise the first tick sets the count to 1.
- R6: In clear-at-end timing (clrAtEnd=1, pwmMode=0), the counter holds the match value until a tick arrives. That tick loads zero and raises matchPulse for that cycle, so zero lasts one full tick period.
- R7: pwmMode=1 overrides clrAtEnd and gives clear-at-start timing with the skip rule of R5.
- R8: flag is high on the cycle after a matchPulse. It stays high until a flagClr cycle without matchPulse, after which it is low on the next cycle.
- R9: When flagClr and matchPulse are high in the same cycle, flag is high on the next cycle.
- R10: While rst is high at a clock edge, the counter, divider, skip state and flag are cleared, so count=0 and flag=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| preEn | input | 1 | Prescaler enable pulse feeding the internal divider |
| extEvent | input | 1 | External count event strobe |
| extSel | input | 1 | 1 = external event is the tick, 0 = divided internal enable |
| ratio | input | RATIO_W | Divide setting, value r divides by r+1 |
| matchVal | input | CNT_W | Match value that ends a period |
| clrAtEnd | input | 1 | 1 = clear-at-end timing, 0 = clear-at-start |
| pwmMode | input | 1 | 1 = PWM-style timing, forcing clear-at-start |
| flagClr | input | 1 | Strobe clearing the sticky flag |
| count | output | CNT_W | Counter value |
| matchPulse | output | 1 | One-cycle pulse on a match |
| flag | output | 1 | Sticky match flag |

## Verification
The bench builds the block with an 8-bit counter and a 2-bit ratio field. This covers every divide setting from one to four, and short match values let many periods pass in each run. It steps through internal and external sources, all four divide settings, both clear timings and the PWM override. Match values of zero and of small numbers bring the hold-at-match and skip-edge corners within reach many times per run. A flag-clear strobe that lands exactly on a match, and a reset in the middle of a period, are also driven.

// File: rtl/mct_pkg.sv
package mct_pkg;

  // Phase of the restart sequence after a clear-at-start clear
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_SKIP = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load0;  // load zero into the counter
    logic step;   // advance the counter by one
    logic hit;    // a match event happens this cycle
  } strobe_t;

endpackage

// File: rtl/mct_ctrl.sv
module mct_ctrl
  import mct_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               preEn,
  input  logic               extEvent,
  input  logic               extSel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               clrAtEnd,
  input  logic               pwmMode,
  input  logic               eqMatch,
  output strobe_t            strobes
);

  logic [RATIO_W-1:0] divCnt;
  logic               divWrap;
  logic               tickInt;
  logic               tick;
  logic               endMode;
  logic               skipNeeded;
  phase_e             phase;
  phase_e             phaseNext;

  // Prescale divider: counts enable pulses, wraps at the ratio setting
  assign divWrap = (divCnt >= ratio);
  assign tickInt = preEn && divWrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (preEn) begin
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
    end
  end

  assign tick       = extSel ? extEvent : tickInt;
  assign endMode    = clrAtEnd && !pwmMode;
  assign skipNeeded = (pwmMode || !extSel) && (ratio != '0);

  always_comb begin
    strobes   = '0;
    phaseNext = phase;
    unique case (phase)
      PH_RUN: begin
        if (endMode) begin
          strobes.hit   = tick && eqMatch;
          strobes.load0 = tick && eqMatch;
          strobes.step  = tick && !eqMatch;
        end else if (eqMatch) begin
          strobes.hit   = 1'b1;
          strobes.load0 = 1'b1;
          phaseNext     = skipNeeded ? PH_SKIP : PH_WAIT;
        end else begin
          strobes.step = tick;
        end
      end
      PH_SKIP: begin
        if (tick) phaseNext = PH_WAIT;
      end
      PH_WAIT: begin
        if (tick) begin
          strobes.step = 1'b1;
          phaseNext    = PH_RUN;
        end
      end
      default: phaseNext = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_RUN;
    else     phase <= phaseNext;
  end

endmodule

// File: rtl/mct_dpath.sv
module mct_dpath
  import mct_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic             flagClr,
  input  logic [CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             eqMatch
);

  assign eqMatch = (count == matchVal);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobes.load0) begin
      count <= '0;
    end else if (strobes.step) begin
      count <= count + 1'b1;
    end
  end

  // Set wins over clear
  always_ff @(posedge clk) begin
    if (rst)              flag <= 1'b0;
    else if (strobes.hit) flag <= 1'b1;
    else if (flagClr)     flag <= 1'b0;
  end

endmodule

// File: rtl/mct_timebase.sv
module mct_timebase
  import mct_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               preEn,
  input  logic               extEvent,
  input  logic               extSel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [CNT_W-1:0]   matchVal,
  input  logic               clrAtEnd,
  input  logic               pwmMode,
  input  logic               flagClr,
  output logic [CNT_W-1:0]   count,
  output logic               matchPulse,
  output logic               flag
);

  strobe_t strobes;
  logic    eqMatch;

  mct_ctrl #(.RATIO_W(RATIO_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .preEn    (preEn),
    .extEvent (extEvent),
    .extSel   (extSel),
    .ratio    (ratio),
    .clrAtEnd (clrAtEnd),
    .pwmMode  (pwmMode),
    .eqMatch  (eqMatch),
    .strobes  (strobes)
  );

  mct_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .flagClr  (flagClr),
    .matchVal (matchVal),
    .count    (count),
    .flag     (flag),
    .eqMatch  (eqMatch)
  );

  assign matchPulse = strobes.hit;

endmodule

// File: rtl/mct_checker.sv
module mct_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clrAtEnd,
  input logic             pwmMode,
  input logic             flagClr,
  input logic [CNT_W-1:0] matchVal,
  input logic [CNT_W-1:0] count,
  input logic             matchPulse,
  input logic             flag
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == '0 || count == $past(count) || count == $past(count) + 1'b1)); // R1

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    matchPulse |=> (count == '0)); // R4

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (matchPulse && !(clrAtEnd && !pwmMode)) |=> !matchPulse); // R4

  AST_END_HOLD: assert property (@(posedge clk) disable iff (rst)
    (clrAtEnd && !pwmMode && count == matchVal && !matchPulse) |=> $stable(count)); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag && !flagClr) |=> flag); // R8

  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
    (flagClr && !matchPulse) |=> !flag); // R8

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    matchPulse |=> flag); // R9

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count == '0 && !flag)); // R10

endmodule

bind mct_timebase mct_checker #(.CNT_W(CNT_W)) uChk (
  .clk        (clk),
  .rst        (rst),
  .clrAtEnd   (clrAtEnd),
  .pwmMode    (pwmMode),
  .flagClr    (flagClr),
  .matchVal   (matchVal),
  .count      (count),
  .matchPulse (matchPulse),
  .flag       (flag)
);

// File: tb/sim_mct_timebase.sv
module sim_mct_timebase;

  localparam int CW = 8;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          preEn;
  logic          extEvent;
  logic          extSel;
  logic [RW-1:0] ratio;
  logic [CW-1:0] matchVal;
  logic          clrAtEnd;
  logic          pwmMode;
  logic          flagClr;
  logic [CW-1:0] count;
  logic          matchPulse;
  logic          flag;

  always #5 clk = ~clk;

  mct_timebase #(.CNT_W(CW), .RATIO_W(RW)) u0 (
    .clk(clk), .rst(rst), .preEn(preEn), .extEvent(extEvent), .extSel(extSel),
    .ratio(ratio), .matchVal(matchVal), .clrAtEnd(clrAtEnd), .pwmMode(pwmMode),
    .flagClr(flagClr), .count(count), .matchPulse(matchPulse), .flag(flag)
  );

  int    total = 0;
  int    bad   = 0;
  string tag   = "R10";

  // Behavioural reference state
  int mCount = 0;
  int mDiv   = 0;
  int mPhase = 0; // 0 counting, 1 ignoring a tick, 2 waiting for first tick
  bit mFlag  = 0;

  bit recOn = 0;
  int recQ[$];

  task automatic check(string t, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  function automatic bit modelTick();
    if (extSel) return extEvent;
    return preEn && (mDiv >= int'(ratio));
  endfunction

  function automatic bit modelPulse();
    bit endM;
    bit eq;
    endM = clrAtEnd && !pwmMode;
    eq   = (mCount == int'(matchVal));
    if (mPhase != 0) return 1'b0;
    if (endM) return modelTick() && eq;
    return eq;
  endfunction

  task automatic runCycle();
    bit tk;
    bit endM;
    bit skipN;
    bit eq;
    bit pulse;
    @(negedge clk);
    tk    = modelTick();
    endM  = clrAtEnd && !pwmMode;
    skipN = (pwmMode || !extSel) && (ratio != 0);
    eq    = (mCount == int'(matchVal));
    pulse = modelPulse();
    if (!rst) check(tag, int'(matchPulse), int'(pulse), "matchPulse");
    check(tag, int'(count), mCount, "count");
    check(tag, int'(flag), int'(mFlag), "flag");
    if (recOn && !rst) recQ.push_back(int'(count));
    if (rst) begin
      mCount = 0; mDiv = 0; mPhase = 0; mFlag = 0;
    end else begin
      if (preEn) mDiv = (mDiv >= int'(ratio)) ? 0 : mDiv + 1;
      if (pulse) mFlag = 1;
      else if (flagClr) mFlag = 0;
      case (mPhase)
        0: begin
          if (endM) begin
            if (tk) mCount = eq ? 0 : (mCount + 1) % 256;
          end else if (eq) begin
            mCount = 0;
            mPhase = skipN ? 1 : 2;
          end else if (tk) begin
            mCount = (mCount + 1) % 256;
          end
        end
        1: if (tk) mPhase = 2;
        default: if (tk) begin mCount = 1; mPhase = 0; end
      endcase
    end
    @(posedge clk);
    #1;
  endtask

  task automatic drive(int pPre, int pExt, int pClr, bit clrOnHit);
    preEn    = ($urandom % 100) < pPre;
    extEvent = ($urandom % 100) < pExt;
    if (clrOnHit) flagClr = modelPulse();
    else          flagClr = ($urandom % 100) < pClr;
  endtask

  task automatic scen(string t, bit xs, int r, int mv, bit ce, bit pw,
                      int pPre, int pExt, int pClr, bit coh, int rstAt, int n);
    tag      = "R10";
    extSel   = xs;
    ratio    = RW'(r);
    matchVal = CW'(mv);
    clrAtEnd = ce;
    pwmMode  = pw;
    rst      = 1'b1;
    drive(0, 0, 0, 0);
    runCycle();
    runCycle();
    rst = 1'b0;
    tag = t;
    for (int i = 0; i < n; i++) begin
      rst = (i == rstAt);
      drive(pPre, pExt, pClr, coh);
      runCycle();
    end
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; preEn = 0; extEvent = 0; extSel = 0; ratio = '0;
    matchVal = '0; clrAtEnd = 0; pwmMode = 0; flagClr = 0;
    @(posedge clk);
    #1;
    runCycle(); // R10 reset state

    // R3: bypassed divider, internal, clear at start, match 3
    recOn = 1;
    scen("R3", 0, 0, 3, 0, 0, 100, 0, 0, 0, -1, 40);
    recOn = 0;
    begin
      int expSeq[8] = '{0, 1, 2, 3, 0, 1, 2, 3};
      for (int i = 0; i < 8; i++) begin
        if (i < recQ.size()) check("R3", recQ[i], expSeq[i], "sequence");
        else check("R3", -1, expSeq[i], "sequence");
      end
    end

    scen("R5",  0, 2, 4, 0, 0, 70,  0,  10, 0, -1, 300);
    scen("R1",  0, 3, 2, 0, 0, 100, 0,  0,  0, -1, 100);
    scen("R4",  0, 1, 6, 0, 0, 100, 0,  0,  0, -1, 100);
    scen("R6",  0, 1, 2, 1, 0, 80,  0,  10, 0, -1, 200);
    scen("R6",  0, 0, 0, 1, 0, 100, 0,  0,  0, -1, 30);
    scen("R2",  1, 2, 5, 0, 0, 50,  40, 10, 0, -1, 300);
    scen("R2",  1, 0, 3, 1, 0, 50,  40, 0,  0, -1, 200);
    scen("R7",  0, 3, 3, 1, 1, 90,  0,  10, 0, -1, 300);
    scen("R7",  1, 1, 2, 0, 1, 50,  50, 0,  0, -1, 200);
    scen("R9",  0, 0, 3, 0, 0, 100, 0,  0,  1, -1, 60);
    scen("R8",  0, 1, 1, 0, 0, 100, 0,  50, 0, -1, 150);
    scen("R10", 0, 2, 3, 0, 0, 60,  0,  10, 0, 50, 120);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule